// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Execute Unit

This block is the arithmetic stage of a packed-data pipeline. Every issue cycle it takes two source words, B and C, and optionally two accumulator words, A and D. It computes lane-wise sums or differences on one 32-bit lane, two 16-bit lanes or four 8-bit lanes. It presents one or two destination words, each with a write enable and a destination index, one clock later. The surrounding pipeline decodes the instruction, reads the register file and supplies the opcode, the add/subtract control, the halfword swizzle code, the rounding choice and the two destination indices.

The operations are:
- dual add/subtract, where each destination picks add or subtract on the same operand pair;
- accumulation into A and D;
- a widening byte add that yields 16-bit lanes;
- rounded averages of unsigned lanes;
- a sum of absolute byte differences.

Lane arithmetic wraps within the lane. No carry crosses a lane boundary. Register index zero is hard-wired to zero and is never written.

Top module: `simd_addsub_unit`

## Requirements
- R1: `valid_o` is high in exactly the cycle after each cycle with `issue_i` high. In cycles without an issue, both write enables are low, and `a_o`, `d_o` and the indices hold their last values.
- R2: When `op_i` = 0 (32-bit dual), `a_o` = B±C with the sign taken from `addsub_i[1]`, and `d_o` = B±C with the sign taken from `addsub_i[0]`. For each bit, 0 selects add and 1 selects subtract. Results wrap modulo 2^32.
- R3: When `op_i` = 1 (16-bit dual), each 16-bit half is computed independently and wraps modulo 2^16. No carry or borrow passes between the halves.
- R4: In 16-bit dual and 16-bit accumulate modes, B is swizzled first according to `swz_i`:
  - 0 keeps {hi,lo};
  - 1 gives {lo,hi};
  - 2 gives {hi,hi};
  - 3 gives {lo,lo}.
  C is never swizzled.
- R5: When `op_i` = 2 (32-bit accumulate) or 3 (16-bit accumulate), the per-destination sum or difference is added lane-wise into `a_i` and `d_i`, and the results are written to A and D.
- R6: When `op_i` = 4 (widening byte), bytes are unsigned and zero-extended to 16 bits.
  - `a_o` is {B[31:24]±C[31:24], B[23:16]±C[23:16]}, with the sign from `addsub_i[1]`.
  - `d_o` is {B[15:8]±C[15:8], B[7:0]±C[7:0]}, with the sign from `addsub_i[0]`.
  - Each 16-bit lane wraps modulo 2^16.
- R7: When `op_i` = 5 (16-bit lanes) or 6 (8-bit lanes), `a_o` is the unsigned lane average. It is floor((b+c)/2) when `rnd_i` = 0 and ceil((b+c)/2) when `rnd_i` = 1, with no loss of the lane carry. D is not written: `d_we_o` = 0 and `d_o` = 0.
- R8: When `op_i` = 7, S is the sum of the four unsigned absolute byte differences |B−C|. `a_o` = S, and `d_o` = `d_i` + S modulo 2^32.
- R9: A destination whose index is zero is never written. Its write enable stays low and its data output reads zero. The other destination is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (see R2–R8) |
| addsub_i | input | 2 | Bit 1: A subtracts; bit 0: D subtracts |
| swz_i | input | 2 | Halfword swizzle code for B |
| rnd_i | input | 1 | Average rounds up when set |
| a_idx_i | input | IDX_W | Destination index for A |
| d_idx_i | input | IDX_W | Destination index for D |
| a_i | input | DATA_W | Accumulator word A |
| b_i | input | DATA_W | Source word B |
| c_i | input | DATA_W | Source word C |
| d_i | input | DATA_W | Accumulator word D |
| valid_o | output | 1 | Result valid |
| a_we_o | output | 1 | Write enable for A |
| d_we_o | output | 1 | Write enable for D |
| a_idx_o | output | IDX_W | Registered A index |
| d_idx_o | output | IDX_W | Registered D index |
| a_o | output | DATA_W | Result for A |
| d_o | output | DATA_W | Result for D |

## Verification
Every result, write enable and index is captured by the clock edge that ends the issue cycle, so each one is due exactly one cycle after the stimulus. The bench drives each operation on a falling edge with `issue_i` high for one cycle. It samples on the next falling edge, after the single capturing rising edge, and never earlier or later. The hold behaviour is checked one idle cycle further on, when `valid_o` and both enables must have dropped while the data outputs keep the previous result.

// File: rtl/simd_as_pkg.sv
package simd_as_pkg;
  typedef enum logic [2:0] {
    OP_ADD32 = 3'd0,
    OP_ADD16 = 3'd1,
    OP_ACC32 = 3'd2,
    OP_ACC16 = 3'd3,
    OP_WADD8 = 3'd4,
    OP_AVG16 = 3'd5,
    OP_AVG8  = 3'd6,
    OP_SAD8  = 3'd7
  } simd_op_e;

  typedef enum logic [1:0] {
    SWZ_KEEP = 2'd0,
    SWZ_EXCH = 2'd1,
    SWZ_HIHI = 2'd2,
    SWZ_LOLO = 2'd3
  } swz_e;
endpackage

// File: rtl/simd_lane_add.sv
module simd_lane_add #(
  parameter int W  = 32,
  parameter int LW = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] r_o
);
  localparam int NL = W / LW;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign r_o[l*LW +: LW] = sub_i ? (x_i[l*LW +: LW] - y_i[l*LW +: LW])
                                   : (x_i[l*LW +: LW] + y_i[l*LW +: LW]);
  end
endmodule

// File: rtl/simd_swizzle.sv
module simd_swizzle
  import simd_as_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] b_i,
  input  logic [1:0]   swz_i,
  output logic [W-1:0] b_o
);
  localparam int HW = W / 2;

  logic [HW-1:0] hi, lo;
  assign hi = b_i[W-1:HW];
  assign lo = b_i[HW-1:0];

  always_comb begin
    unique case (swz_e'(swz_i))
      SWZ_EXCH: b_o = {lo, hi};
      SWZ_HIHI: b_o = {hi, hi};
      SWZ_LOLO: b_o = {lo, lo};
      default:  b_o = {hi, lo};
    endcase
  end
endmodule

// File: rtl/simd_avg.sv
module simd_avg #(
  parameter int W  = 32,
  parameter int LW = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         rnd_i,
  output logic [W-1:0] r_o
);
  localparam int NL = W / LW;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LW:0] sum_l;  // one guard bit keeps the carry before the shift
    assign sum_l = {1'b0, x_i[l*LW +: LW]} + {1'b0, y_i[l*LW +: LW]}
                 + {{LW{1'b0}}, rnd_i};
    assign r_o[l*LW +: LW] = sum_l[LW:1];
  end
endmodule

// File: rtl/simd_sad.sv
module simd_sad #(
  parameter int W  = 32,
  parameter int LW = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  localparam int NL = W / LW;

  logic [LW-1:0] diff [NL];

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LW-1:0] xl, yl;
    assign xl = x_i[l*LW +: LW];
    assign yl = y_i[l*LW +: LW];
    assign diff[l] = (xl > yl) ? (xl - yl) : (yl - xl);
  end

  always_comb begin
    sum_o = '0;
    for (int l = 0; l < NL; l++) sum_o = sum_o + {{(W-LW){1'b0}}, diff[l]};
  end
endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
  import simd_as_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        addsub_i,
  input  logic [1:0]        swz_i,
  input  logic              rnd_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  input  logic [IDX_W-1:0]  d_idx_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic [DATA_W-1:0] d_i,
  output logic              valid_o,
  output logic              a_we_o,
  output logic              d_we_o,
  output logic [IDX_W-1:0]  a_idx_o,
  output logic [IDX_W-1:0]  d_idx_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] d_o
);
  localparam int HW = DATA_W / 2;
  localparam int QW = DATA_W / 4;

  simd_op_e op;
  logic     sub_a, sub_d, wide;
  assign op    = simd_op_e'(op_i);
  assign sub_a = addsub_i[1];
  assign sub_d = addsub_i[0];
  assign wide  = (op == OP_WADD8);

  // 32-bit dual path
  logic [DATA_W-1:0] s32_a, s32_d, acc32_a, acc32_d;
  simd_lane_add #(.W(DATA_W), .LW(DATA_W)) u_add32_a (
    .x_i(b_i), .y_i(c_i), .sub_i(sub_a), .r_o(s32_a));
  simd_lane_add #(.W(DATA_W), .LW(DATA_W)) u_add32_d (
    .x_i(b_i), .y_i(c_i), .sub_i(sub_d), .r_o(s32_d));
  simd_lane_add #(.W(DATA_W), .LW(DATA_W)) u_acc32_a (
    .x_i(a_i), .y_i(s32_a), .sub_i(1'b0), .r_o(acc32_a));
  simd_lane_add #(.W(DATA_W), .LW(DATA_W)) u_acc32_d (
    .x_i(d_i), .y_i(s32_d), .sub_i(1'b0), .r_o(acc32_d));

  // 16-bit lanes, shared by swizzled halfword ops and zero-extended bytes
  logic [DATA_W-1:0] b_swz, x16_a, y16_a, x16_d, y16_d;
  logic [DATA_W-1:0] s16_a, s16_d, acc16_a, acc16_d;
  simd_swizzle #(.W(DATA_W)) u_swz (.b_i(b_i), .swz_i(swz_i), .b_o(b_swz));

  assign x16_a = wide ? {{QW{1'b0}}, b_i[4*QW-1:3*QW], {QW{1'b0}}, b_i[3*QW-1:2*QW]} : b_swz;
  assign y16_a = wide ? {{QW{1'b0}}, c_i[4*QW-1:3*QW], {QW{1'b0}}, c_i[3*QW-1:2*QW]} : c_i;
  assign x16_d = wide ? {{QW{1'b0}}, b_i[2*QW-1:QW],   {QW{1'b0}}, b_i[QW-1:0]}      : b_swz;
  assign y16_d = wide ? {{QW{1'b0}}, c_i[2*QW-1:QW],   {QW{1'b0}}, c_i[QW-1:0]}      : c_i;

  simd_lane_add #(.W(DATA_W), .LW(HW)) u_add16_a (
    .x_i(x16_a), .y_i(y16_a), .sub_i(sub_a), .r_o(s16_a));
  simd_lane_add #(.W(DATA_W), .LW(HW)) u_add16_d (
    .x_i(x16_d), .y_i(y16_d), .sub_i(sub_d), .r_o(s16_d));
  simd_lane_add #(.W(DATA_W), .LW(HW)) u_acc16_a (
    .x_i(a_i), .y_i(s16_a), .sub_i(1'b0), .r_o(acc16_a));
  simd_lane_add #(.W(DATA_W), .LW(HW)) u_acc16_d (
    .x_i(d_i), .y_i(s16_d), .sub_i(1'b0), .r_o(acc16_d));

  // averages
  logic [DATA_W-1:0] avg16, avg8;
  simd_avg #(.W(DATA_W), .LW(HW)) u_avg16 (
    .x_i(b_i), .y_i(c_i), .rnd_i(rnd_i), .r_o(avg16));
  simd_avg #(.W(DATA_W), .LW(QW)) u_avg8 (
    .x_i(b_i), .y_i(c_i), .rnd_i(rnd_i), .r_o(avg8));

  // sum of absolute differences
  logic [DATA_W-1:0] sad, sad_acc;
  simd_sad #(.W(DATA_W), .LW(QW)) u_sad (.x_i(b_i), .y_i(c_i), .sum_o(sad));
  simd_lane_add #(.W(DATA_W), .LW(DATA_W)) u_sad_acc (
    .x_i(d_i), .y_i(sad), .sub_i(1'b0), .r_o(sad_acc));

  // result select
  logic [DATA_W-1:0] res_a, res_d;
  logic              wr_d;
  always_comb begin
    res_a = '0;
    res_d = '0;
    wr_d  = 1'b1;
    unique case (op)
      OP_ADD32: begin res_a = s32_a;   res_d = s32_d;   end
      OP_ACC32: begin res_a = acc32_a; res_d = acc32_d; end
      OP_ADD16,
      OP_WADD8: begin res_a = s16_a;   res_d = s16_d;   end
      OP_ACC16: begin res_a = acc16_a; res_d = acc16_d; end
      OP_AVG16: begin res_a = avg16;   wr_d = 1'b0;     end
      OP_AVG8:  begin res_a = avg8;    wr_d = 1'b0;     end
      OP_SAD8:  begin res_a = sad;     res_d = sad_acc; end
      default:  ;
    endcase
  end

  logic a_wr, d_wr;
  assign a_wr = (a_idx_i != '0);
  assign d_wr = wr_d && (d_idx_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      a_we_o  <= 1'b0;
      d_we_o  <= 1'b0;
      a_idx_o <= '0;
      d_idx_o <= '0;
      a_o     <= '0;
      d_o     <= '0;
    end else begin
      valid_o <= issue_i;
      a_we_o  <= issue_i && a_wr;
      d_we_o  <= issue_i && d_wr;
      if (issue_i) begin
        a_idx_o <= a_idx_i;
        d_idx_o <= d_idx_i;
        a_o     <= a_wr ? res_a : '0;
        d_o     <= d_wr ? res_d : '0;
      end
    end
  end
endmodule

// File: rtl/simd_addsub_unit_chk.sv
module simd_addsub_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_i,
  input logic [2:0]        op_i,
  input logic [1:0]        addsub_i,
  input logic              valid_o,
  input logic              a_we_o,
  input logic              d_we_o,
  input logic [IDX_W-1:0]  a_idx_o,
  input logic [IDX_W-1:0]  d_idx_o,
  input logic [DATA_W-1:0] a_o,
  input logic [DATA_W-1:0] d_o
);
  localparam int HW = DATA_W / 2;
  localparam int QW = DATA_W / 4;

  // R1
  valid_follows_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> valid_o);
  // R1
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> !valid_o);
  // R1
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> ($stable(a_o) && $stable(d_o) && $stable(a_idx_o) && $stable(d_idx_o)));
  // R1
  we_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_we_o || d_we_o) |-> valid_o);
  // R9
  a_zero_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_we_o |-> (a_idx_o != '0));
  // R9
  d_zero_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_we_o |-> (d_idx_o != '0));
  // R7
  avg_no_d_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && (op_i == 3'd5 || op_i == 3'd6)) |=> (!d_we_o && d_o == '0));
  // R6
  wide_add_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && op_i == 3'd4 && addsub_i == 2'b00) |=>
      (a_o[HW-1:QW+1] == '0 && a_o[DATA_W-1:HW+QW+1] == '0 &&
       d_o[HW-1:QW+1] == '0 && d_o[DATA_W-1:HW+QW+1] == '0));
  // R8
  sad_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && op_i == 3'd7) |=> (a_o[DATA_W-1:QW+2] == '0));
endmodule

bind simd_addsub_unit simd_addsub_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(issue_i), .op_i(op_i),
  .addsub_i(addsub_i), .valid_o(valid_o), .a_we_o(a_we_o), .d_we_o(d_we_o),
  .a_idx_o(a_idx_o), .d_idx_o(d_idx_o), .a_o(a_o), .d_o(d_o));

// File: tb/tb_simd_addsub_unit.sv
`timescale 1ns/1ps
module tb_simd_addsub_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  addsub = '0, swz = '0;
  logic        rnd = 1'b0;
  logic [3:0]  a_idx = 4'd1, d_idx = 4'd2;
  logic [31:0] a_in = '0, b_in = '0, c_in = '0, d_in = '0;
  logic        valid, a_we, d_we;
  logic [3:0]  a_idx_q, d_idx_q;
  logic [31:0] a_out, d_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  simd_addsub_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .op_i(op), .addsub_i(addsub),
    .swz_i(swz), .rnd_i(rnd), .a_idx_i(a_idx), .d_idx_i(d_idx),
    .a_i(a_in), .b_i(b_in), .c_i(c_in), .d_i(d_in),
    .valid_o(valid), .a_we_o(a_we), .d_we_o(d_we),
    .a_idx_o(a_idx_q), .d_idx_o(d_idx_q), .a_o(a_out), .d_o(d_out));

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  as;
    logic [1:0]  swz;
    logic        rnd;
    logic [31:0] a, b, c, d, ea, ed;
    logic        ewd;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'b00, 2'd0, 1'b0, 32'h0, 32'h5, 32'h3, 32'h0, 32'h8, 32'h8, 1'b1},
    '{3'd0, 2'b01, 2'd0, 1'b0, 32'h0, 32'h5, 32'h3, 32'h0, 32'h8, 32'h2, 1'b1},
    '{3'd0, 2'b10, 2'd0, 1'b0, 32'h0, 32'h3, 32'h5, 32'h0, 32'hFFFF_FFFE, 32'h8, 1'b1},
    '{3'd1, 2'b00, 2'd0, 1'b0, 32'h0, 32'h0001_FFFF, 32'h0002_0001, 32'h0, 32'h0003_0000, 32'h0003_0000, 1'b1},
    '{3'd1, 2'b01, 2'd1, 1'b0, 32'h0, 32'h0010_0020, 32'h0001_0002, 32'h0, 32'h0021_0012, 32'h001F_000E, 1'b1},
    '{3'd1, 2'b11, 2'd2, 1'b0, 32'h0, 32'h0010_0020, 32'h0001_0002, 32'h0, 32'h000F_000E, 32'h000F_000E, 1'b1},
    '{3'd1, 2'b00, 2'd3, 1'b0, 32'h0, 32'h0010_0020, 32'h0001_0002, 32'h0, 32'h0021_0022, 32'h0021_0022, 1'b1},
    '{3'd2, 2'b01, 2'd0, 1'b0, 32'h64, 32'h5, 32'h3, 32'h10, 32'h6C, 32'h12, 1'b1},
    '{3'd3, 2'b10, 2'd0, 1'b0, 32'h0001_0001, 32'h0005_0007, 32'h0002_0001, 32'h0100_0100, 32'h0004_0007, 32'h0107_0108, 1'b1},
    '{3'd4, 2'b00, 2'd0, 1'b0, 32'h0, 32'hFF80_0102, 32'hFF80_0304, 32'h0, 32'h01FE_0100, 32'h0004_0006, 1'b1},
    '{3'd4, 2'b11, 2'd0, 1'b0, 32'h0, 32'h0110_0001, 32'h0201_0002, 32'h0, 32'hFFFF_000F, 32'h0000_FFFF, 1'b1},
    '{3'd5, 2'b00, 2'd0, 1'b0, 32'h0, 32'hFFFF_0003, 32'hFFFF_0004, 32'h0, 32'hFFFF_0003, 32'h0, 1'b0},
    '{3'd5, 2'b00, 2'd0, 1'b1, 32'h0, 32'hFFFF_0003, 32'hFFFF_0004, 32'h0, 32'hFFFF_0004, 32'h0, 1'b0},
    '{3'd6, 2'b00, 2'd0, 1'b0, 32'h0, 32'hFF01_0203, 32'hFF02_0206, 32'h0, 32'hFF01_0204, 32'h0, 1'b0},
    '{3'd6, 2'b00, 2'd0, 1'b1, 32'h0, 32'hFF01_0203, 32'hFF02_0206, 32'h0, 32'hFF02_0205, 32'h0, 1'b0},
    '{3'd7, 2'b00, 2'd0, 1'b0, 32'h0, 32'h0A00_FF10, 32'h0300_0020, 32'h100, 32'h116, 32'h216, 1'b1}
  };

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0:      return "R2";
      3'd1:      return "R4";
      3'd2, 3'd3: return "R5";
      3'd4:      return "R6";
      3'd5, 3'd6: return "R7";
      default:   return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive on falling edge, one capture edge, sample on next falling edge
  task automatic issue_op(input logic [2:0] o, input logic [1:0] as, input logic [1:0] sw,
                          input logic r, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] d);
    @(negedge clk);
    op = o; addsub = as; swz = sw; rnd = r;
    a_in = a; b_in = b; c_in = c; d_in = d;
    issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R1", "reset valid", {31'b0, valid}, 32'h0);
    check("R1", "reset a_we", {31'b0, a_we}, 32'h0);
    check("R1", "reset a_o", a_out, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue_op(VEC[i].op, VEC[i].as, VEC[i].swz, VEC[i].rnd,
               VEC[i].a, VEC[i].b, VEC[i].c, VEC[i].d);
      check("R1", "valid", {31'b0, valid}, 32'h1);
      check(req_of(VEC[i].op), "a_o", a_out, VEC[i].ea);
      check(req_of(VEC[i].op), "d_o", d_out, VEC[i].ed);
      check(req_of(VEC[i].op), "d_we", {31'b0, d_we}, {31'b0, VEC[i].ewd});
    end

    // R2 wraparound on the single lane
    issue_op(3'd0, 2'b00, 2'd0, 1'b0, 0, 32'hFFFF_FFFF, 32'h1, 0);
    check("R2", "wrap a_o", a_out, 32'h0);

    // R3 no carry between halves
    issue_op(3'd1, 2'b01, 2'd0, 1'b0, 0, 32'h7FFF_FFFF, 32'h0001_0001, 0);
    check("R3", "lane add", a_out, 32'h8000_0000);
    check("R3", "lane sub", d_out, 32'h7FFE_FFFE);

    // R4 C not swizzled in accumulate mode (exchange applies to B only)
    issue_op(3'd3, 2'b00, 2'd1, 1'b0, 32'h0, 32'h0001_0002, 32'h0010_0020, 32'h0);
    check("R4", "acc swizzle", a_out, 32'h0012_0021);

    // R1 hold during idle cycle
    @(negedge clk);
    check("R1", "idle valid", {31'b0, valid}, 32'h0);
    check("R1", "idle we", {30'b0, a_we, d_we}, 32'h0);
    check("R1", "hold a_o", a_out, 32'h0012_0021);

    // R9 zero destination index on A only
    a_idx = 4'd0; d_idx = 4'd5;
    issue_op(3'd0, 2'b00, 2'd0, 1'b0, 0, 32'h5, 32'h3, 0);
    check("R9", "a_we", {31'b0, a_we}, 32'h0);
    check("R9", "a_o", a_out, 32'h0);
    check("R9", "d_we", {31'b0, d_we}, 32'h1);
    check("R9", "d_o", d_out, 32'h8);
    check("R9", "d_idx", {28'b0, d_idx_q}, 32'h5);

    // R9 zero destination index on D
    a_idx = 4'd3; d_idx = 4'd0;
    issue_op(3'd7, 2'b00, 2'd0, 1'b0, 0, 32'h0000_0005, 32'h0, 32'h7);
    check("R9", "sad d_we", {31'b0, d_we}, 32'h0);
    check("R9", "sad d_o", d_out, 32'h0);
    check("R8", "sad a_o", a_out, 32'h5);

    finish_run();
  end
endmodule